// File: doc/BRIEF.md
# Shared-Cache Event Counter Bank

This block is a bank of eight event counters for a performance monitor that sits beside a shared cache. Each cycle, the cache logic raises any number of pulses on a 256-wide event vector, one line per event code. Each counter watches the single line named by its own 8-bit selector. A counter advances by one on each cycle that its line is high, provided both its own enable bit and the global run bit are set.

Software reaches the bank through a simple register port. Writes may be 32-bit or 64-bit, and reads are combinational. Counters can be read, preset and cleared through this port. When a counter wraps, it records a pending bit in an interrupt status register. An interrupt line goes high while any unmasked pending bit is set.

The build parameter `CNT_W` sets the counter width to 48 or 64 bits. The bank also holds data-source selector fields. These are stored and read back but do not steer counting.

Top module: `evt_cnt_bank`

## Requirements
- R1: Counter n is a 64-bit register at offset 0x100 + 8*n. A 64-bit write or read at that offset moves the whole value. A 32-bit write at that offset changes only bits 31:0. A 32-bit access at offset +4 writes or reads bits 63:32, carried in data bits 31:0.
- R2: With `CNT_W` = 48, counter bits 63:48 always read as zero, and write data in those bits is dropped.
- R3: Selector words sit at 0x020 (counters 0..3) and 0x024 (counters 4..7). Counter n takes its code from bits 8*(n mod 4)+7 : 8*(n mod 4). A code of 0xFF selects nothing, and that counter never advances. Both words reset to 0xFFFFFFFF.
- R4: Bit 16 of the control word at 0x000 is the global run bit, and it resets to 0. While it is clear, no counter advances.
- R5: The enable word at 0x008 holds one bit per counter, and bit n enables counter n. It resets to 0. A disabled counter holds its value.
- R6: An enabled counter increases by exactly one on each clock cycle in which its selected event line is high.
- R7: The pending word at 0x018 is read-only. Writing to 0x01C clears every pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged.
- R8: The mask word at 0x010 resets to 0xFF. Bit n = 1 blocks counter n from the interrupt. `irq` is high exactly when a pending bit is set whose mask bit is 0.
- R9: When a counter steps from all ones (at `CNT_W` bits) to zero, its pending bit is set on that same edge, and later events keep counting up from zero.
- R10: If a register write hits a counter on the same cycle that the counter's event is high, the written value is stored and the event is dropped.
- R11: Data-source selector words at 0x028 and 0x02C use the same lane layout as R3. They reset to zero and read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for one cycle |
| regWide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| regRdata | output | 64 | Combinational read data for `regAddr` |
| eventPulse | input | 256 | One pulse line per event code |
| irq | output | 1 | High while an unmasked overflow is pending |

## Verification
The checker assumes that the event vector and the register port change only between clock edges. It also assumes that a register write lasts exactly one cycle. Its hold properties treat any register write as a possible disturbance, so they only claim stability on cycles without one. The bench drives every input on the falling edge and holds each write for one cycle. It samples the combinational read data one time step after setting the address, so the stimulus stays inside these assumptions.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int NUM_CNT = 8;
  localparam int SEL_W   = 8;
  localparam int NUM_EVT = 1 << SEL_W;
  localparam int LANES   = 32 / SEL_W;
  localparam logic [SEL_W-1:0] SEL_NONE = '1;

  localparam int A_CTRL  = 'h000;
  localparam int A_EN    = 'h008;
  localparam int A_MASK  = 'h010;
  localparam int A_STAT  = 'h018;
  localparam int A_CLR   = 'h01C;
  localparam int A_SEL   = 'h020;
  localparam int A_SRC   = 'h028;
  localparam int A_CNT   = 'h100;
  localparam int GO_BIT  = 16;

  typedef struct packed {
    logic [NUM_CNT-1:0] wrLo;
    logic [NUM_CNT-1:0] wrHi;
    logic [31:0]        loWord;
    logic [31:0]        hiWord;
    logic [NUM_CNT-1:0] countEn;
  } dpStrobe_t;
endpackage

// File: rtl/evt_bank_ctrl.sv
module evt_bank_ctrl
  import evt_bank_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           regWr,
  input  logic                           regWide,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [63:0]                    regWdata,
  output logic [63:0]                    regRdata,
  input  logic [NUM_CNT-1:0][63:0]       cntVal,
  input  logic [NUM_CNT-1:0]             ovfPulse,
  output dpStrobe_t                      strb,
  output logic [NUM_CNT-1:0][SEL_W-1:0]  evSel,
  output logic                           goBit,
  output logic [NUM_CNT-1:0]             irqStat,
  output logic [NUM_CNT-1:0]             irqMask,
  output logic                           irq
);
  localparam int IDX_W = $clog2(NUM_CNT);

  logic [NUM_CNT-1:0]            cntEnQ;
  logic [NUM_CNT-1:0][SEL_W-1:0] srcSel;
  logic [ADDR_W-1:0]             cntOffs;
  logic [IDX_W-1:0]              cntIdx;
  logic                          isCnt, hiHalf;
  logic [NUM_CNT-1:0]            clrBits;

  assign cntOffs = regAddr - ADDR_W'(A_CNT);
  assign cntIdx  = cntOffs[3 +: IDX_W];
  assign hiHalf  = regAddr[2];
  assign isCnt   = (regAddr >= ADDR_W'(A_CNT)) && (regAddr < ADDR_W'(A_CNT + 8 * NUM_CNT));
  assign clrBits = (regWr && regAddr == ADDR_W'(A_CLR)) ? regWdata[NUM_CNT-1:0] : '0;

  always_comb begin
    strb.loWord  = regWdata[31:0];
    strb.hiWord  = regWide ? regWdata[63:32] : regWdata[31:0];
    strb.countEn = goBit ? cntEnQ : '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      strb.wrLo[i] = regWr && isCnt && cntIdx == IDX_W'(i) && !hiHalf;
      strb.wrHi[i] = regWr && isCnt && cntIdx == IDX_W'(i) && (hiHalf || regWide);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      goBit   <= 1'b0;
      cntEnQ  <= '0;
      irqMask <= '1;
      irqStat <= '0;
    end else begin
      irqStat <= (irqStat & ~clrBits) | ovfPulse;
      if (regWr && regAddr == ADDR_W'(A_CTRL)) goBit   <= regWdata[GO_BIT];
      if (regWr && regAddr == ADDR_W'(A_EN))   cntEnQ  <= regWdata[NUM_CNT-1:0];
      if (regWr && regAddr == ADDR_W'(A_MASK)) irqMask <= regWdata[NUM_CNT-1:0];
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_lane
    localparam int WORD = n / LANES;
    localparam int LSB  = SEL_W * (n % LANES);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evSel[n]  <= SEL_NONE;
        srcSel[n] <= '0;
      end else if (regWr) begin
        if (regAddr == ADDR_W'(A_SEL + 4 * WORD)) evSel[n]  <= regWdata[LSB +: SEL_W];
        if (regAddr == ADDR_W'(A_SRC + 4 * WORD)) srcSel[n] <= regWdata[LSB +: SEL_W];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (isCnt) begin
      regRdata = hiHalf ? {32'b0, cntVal[cntIdx][63:32]} : cntVal[cntIdx];
    end else begin
      for (int w = 0; w < NUM_CNT / LANES; w++) begin
        if (regAddr == ADDR_W'(A_SEL + 4 * w))
          for (int l = 0; l < LANES; l++) regRdata[SEL_W*l +: SEL_W] = evSel[w*LANES+l];
        if (regAddr == ADDR_W'(A_SRC + 4 * w))
          for (int l = 0; l < LANES; l++) regRdata[SEL_W*l +: SEL_W] = srcSel[w*LANES+l];
      end
      if (regAddr == ADDR_W'(A_CTRL)) regRdata[GO_BIT] = goBit;
      if (regAddr == ADDR_W'(A_EN))   regRdata[NUM_CNT-1:0] = cntEnQ;
      if (regAddr == ADDR_W'(A_MASK)) regRdata[NUM_CNT-1:0] = irqMask;
      if (regAddr == ADDR_W'(A_STAT)) regRdata[NUM_CNT-1:0] = irqStat;
    end
  end

  assign irq = |(irqStat & ~irqMask);
endmodule

// File: rtl/evt_bank_dp.sv
module evt_bank_dp
  import evt_bank_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  dpStrobe_t                      strb,
  input  logic [NUM_CNT-1:0][SEL_W-1:0]  evSel,
  input  logic [NUM_EVT-1:0]             eventPulse,
  output logic [NUM_CNT-1:0][63:0]       cntVal,
  output logic [NUM_CNT-1:0]             ovfPulse
);
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;
    logic [63:0]      wrMerge;
    logic             hit, wrAny;

    assign hit   = strb.countEn[n] && evSel[n] != SEL_NONE && eventPulse[evSel[n]];
    assign wrAny = strb.wrLo[n] || strb.wrHi[n];

    always_comb begin
      wrMerge = '0;
      wrMerge[CNT_W-1:0] = cntQ;
      cntVal[n] = wrMerge;
      if (strb.wrLo[n]) wrMerge[31:0]  = strb.loWord;
      if (strb.wrHi[n]) wrMerge[63:32] = strb.hiWord;
    end

    assign ovfPulse[n] = hit && !wrAny && (&cntQ);

    always_ff @(posedge clk) begin
      if (!rst_n)     cntQ <= '0;
      else if (wrAny) cntQ <= wrMerge[CNT_W-1:0];
      else if (hit)   cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_bank_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int ADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWr,
  input  logic               regWide,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [63:0]        regWdata,
  output logic [63:0]        regRdata,
  input  logic [NUM_EVT-1:0] eventPulse,
  output logic               irq
);
  dpStrobe_t                     strb;
  logic [NUM_CNT-1:0][SEL_W-1:0] evSel;
  logic [NUM_CNT-1:0][63:0]      cntVal;
  logic [NUM_CNT-1:0]            ovfPulse, irqStat, irqMask;
  logic                          goBit;

  evt_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regWide(regWide),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cntVal(cntVal), .ovfPulse(ovfPulse), .strb(strb), .evSel(evSel),
    .goBit(goBit), .irqStat(irqStat), .irqMask(irqMask), .irq(irq)
  );

  evt_bank_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .evSel(evSel),
    .eventPulse(eventPulse), .cntVal(cntVal), .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/evt_cnt_bank_chk.sv
module evt_cnt_bank_chk
  import evt_bank_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          regWr,
  input logic                          goBit,
  input logic                          irq,
  input logic [NUM_CNT-1:0]            irqStat,
  input logic [NUM_CNT-1:0]            irqMask,
  input logic [NUM_CNT-1:0][SEL_W-1:0] evSel,
  input logic [NUM_CNT-1:0][63:0]      cntVal
);
  localparam logic [63:0] ONES = (64'd1 << CNT_W) - 64'd1;

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!goBit && !regWr) |=> $stable(cntVal));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !regWr |=> ((irqStat & $past(irqStat)) == $past(irqStat)));

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irqStat & ~irqMask) != '0);

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_a
    p_none_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evSel[n] == SEL_NONE && !regWr) |=> $stable(cntVal[n]));

    p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(regWr) && $past(cntVal[n]) == ONES && cntVal[n] == '0) |-> irqStat[n]);
  end
endmodule

bind evt_cnt_bank evt_cnt_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWr(regWr), .goBit(goBit), .irq(irq),
  .irqStat(irqStat), .irqMask(irqMask), .evSel(evSel), .cntVal(cntVal)
);

// File: tb/evt_cnt_bank_bench.sv
`timescale 1ns/1ps
module evt_cnt_bank_bench;
  localparam int CNT_W  = 48;
  localparam int ADDR_W = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              regWr = 1'b0;
  logic              regWide = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [63:0]       regWdata = '0;
  logic [63:0]       regRdata;
  logic [255:0]      eventPulse = '0;
  logic              irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  evt_cnt_bank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_evt_cnt_bank (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regWide(regWide),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .eventPulse(eventPulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [63:0] data, input logic wide);
    @(negedge clk);
    regWr = 1'b1; regWide = wide; regAddr = ADDR_W'(addr); regWdata = data;
    @(negedge clk);
    regWr = 1'b0; regWide = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [63:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr);
    #1 data = regRdata;
  endtask

  task automatic pulse(input int code, input int n);
    @(negedge clk);
    eventPulse[code] = 1'b1;
    repeat (n) @(negedge clk);
    eventPulse[code] = 1'b0;
  endtask

  function automatic int cntAddr(input int n);
    return 'h100 + 8 * n;
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    rd('h000, v); check("R4 reset ctrl", v, 64'h0);
    rd('h008, v); check("R5 reset enable", v, 64'h0);
    rd('h010, v); check("R8 reset mask", v, 64'hFF);
    rd('h020, v); check("R3 reset selector", v, 64'hFFFF_FFFF);
    rd('h028, v); check("R11 reset source", v, 64'h0);
    rd(cntAddr(0), v); check("R1 reset counter", v, 64'h0);
    check("R8 reset irq", {63'b0, irq}, 64'h0);
  endtask

  task automatic t_count();
    logic [63:0] v;
    wr('h020, 64'h07FF_FF05, 1'b0);
    wr('h024, 64'hFFFF_05FF, 1'b0);
    wr('h008, 64'h23, 1'b0);
    wr('h000, 64'h1_0000, 1'b0);
    pulse(5, 10);
    rd(cntAddr(0), v); check("R6 counter0 ten events", v, 64'd10);
    rd(cntAddr(5), v); check("R3 counter5 lane1 of word1", v, 64'd10);
    rd(cntAddr(1), v); check("R3 selector none holds", v, 64'd0);
  endtask

  task automatic t_gating();
    logic [63:0] v;
    wr('h000, 64'h0, 1'b0);
    pulse(5, 4);
    rd(cntAddr(0), v); check("R4 global off holds", v, 64'd10);
    wr('h000, 64'h1_0000, 1'b0);
    wr('h008, 64'h20, 1'b0);
    pulse(5, 3);
    rd(cntAddr(0), v); check("R5 disabled counter holds", v, 64'd10);
    rd(cntAddr(5), v); check("R5 enabled counter runs", v, 64'd13);
  endtask

  task automatic t_access();
    logic [63:0] v;
    wr(cntAddr(2), 64'hDEAD_BEEF_1234_5678, 1'b1);
    rd(cntAddr(2), v); check("R2 upper bits dropped", v, 64'h0000_BEEF_1234_5678);
    wr(cntAddr(2) + 4, 64'hFFFF_0001, 1'b0);
    rd(cntAddr(2), v); check("R1 high half write", v, 64'h0001_1234_5678);
    rd(cntAddr(2) + 4, v); check("R1 high half read", v, 64'h1);
    wr(cntAddr(2), 64'h0000_00AA, 1'b0);
    rd(cntAddr(2), v); check("R1 low half write", v, 64'h0001_0000_00AA);
  endtask

  task automatic t_overflow();
    logic [63:0] v;
    wr(cntAddr(3), 64'h0000_FFFF_FFFF_FFFE, 1'b1);
    wr('h008, 64'h08, 1'b0);
    wr('h010, 64'hF7, 1'b0);
    rd('h018, v); check("R7 no pending before wrap", v, 64'h0);
    pulse(7, 3);
    rd(cntAddr(3), v); check("R9 keeps counting after wrap", v, 64'h1);
    rd('h018, v); check("R9 wrap sets pending", v, 64'h08);
    check("R8 unmasked irq", {63'b0, irq}, 64'h1);
    wr('h01C, 64'h0, 1'b0);
    rd('h018, v); check("R7 zero clear no effect", v, 64'h08);
    wr('h010, 64'hFF, 1'b0);
    #1 check("R8 masked irq low", {63'b0, irq}, 64'h0);
    wr('h010, 64'hF7, 1'b0);
    wr('h01C, 64'h08, 1'b0);
    rd('h018, v); check("R7 one clears pending", v, 64'h0);
    check("R8 irq after clear", {63'b0, irq}, 64'h0);
  endtask

  task automatic t_collide();
    logic [63:0] v;
    wr('h008, 64'h01, 1'b0);
    @(negedge clk);
    eventPulse[5] = 1'b1;
    regWr = 1'b1; regWide = 1'b1; regAddr = ADDR_W'(cntAddr(0)); regWdata = 64'd100;
    @(negedge clk);
    regWr = 1'b0; regWide = 1'b0; eventPulse[5] = 1'b0;
    rd(cntAddr(0), v); check("R10 write wins over event", v, 64'd100);
  endtask

  task automatic t_source();
    logic [63:0] v;
    wr('h028, 64'h1122_3344, 1'b0);
    rd('h028, v); check("R11 source word0 readback", v, 64'h1122_3344);
    rd('h02C, v); check("R11 source word1 untouched", v, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_gating();
    t_access();
    t_overflow();
    t_collide();
    t_source();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule